// File: doc/BRIEF.md
# Crossbar Routing Select Controller

This block is the control plane of a four-input, three-output crossbar. For every output port it decides which input drives it, or whether the port stays high-impedance, and whether pre-emphasis is enabled on that port. The data path is modelled as a plain digital multiplexer of the input bits. Analog drivers and the shaping of pre-emphasis pulses are not part of this block.

Routing comes from one of two sources. The first is a set of six three-level strap pins, which arrive already decoded. The second is a pair of routing register bytes, written over a serial-interface register port. When all straps are open, the block runs in LIN mode and routing comes from the registers. Otherwise the straps set the routing until a register override is armed, and I2C is the active interface. A three-level power pin selects power-down, pre-emphasis forced on, or pre-emphasis taken from the registers. Straps are captured only when reset is released and when the block wakes from power-down.

Top module: `xbar_route_ctrl`

## Requirements
- R1: After reset with all straps open and the power pin high, `linMode`=1 and `outEn`, `selCode`, `preEmph` and `dataOut` are all zero.
- R2: Routing register 1 (address 1) holds port 0 in bits 2:0 (pre-emphasis bit 3) and port 1 in bits 6:4 (pre-emphasis bit 7). Register 2 (address 2) holds port 2 in bits 2:0 (pre-emphasis bit 3), and its bits 7:4 are ignored. The source codes are 000 = high-Z, 001 = input 1, 010 = input 0, 011 = input 2 and 100 = input 3. A write shows on the outputs right after the clock edge that takes it. `dataOut[p]` follows the selected input combinationally.
- R3: The source codes 101, 110 and 111 act as high-Z: the port reports `selCode` 000 and `outEn` 0.
- R4: Three-level inputs use 00 = low, 01 = open, 10 = high and 11 = open. Strap pin k sits at `strapPins[2k+1:2k]`. A latched strap set that is not all open gives `linMode`=0. Output p then takes its source from the pin pair (first = pin 5-p, second = pin p), as follows:
  - low/low selects input 0.
  - low/open selects input 1.
  - low/high selects input 2.
  - open/low selects input 3.
  - Any other combination selects high-Z.
- R5: In strap mode the registers do not route the outputs. Writing 0xFF to address 3 arms an override, and from the next edge the registers drive routing. Any other value written to address 3 has no effect.
- R6: A change on the strap pins while the block is powered has no effect on mode or routing, whether or not the override is armed.
- R7: While the power pin is low, `outEn`, `selCode`, `preEmph` and `dataOut` are zero, effective immediately. Register writes made during that time are ignored, and the registers keep their values. Routing resumes when the pin leaves low.
- R8: On the first clock edge where the power pin is not low after being low, the straps are resampled and the override is cleared.
- R9: With the power pin open (01 or 11), `preEmph` is all ones. With the pin high, each port's pre-emphasis follows its register bit.
- R10: A port with `outEn` = 0 drives `dataOut` = 0.
- R11: Writes to address 0 have no effect on routing or pre-emphasis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrPin | input | 2 | Three-level power / pre-emphasis pin |
| strapPins | input | 12 | Six decoded three-level strap pins, 2 bits each |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| dataIn | input | 4 | Crossbar input bits |
| dataOut | output | 3 | Crossbar output bits |
| outEn | output | 3 | Per-port output enable (0 = high-Z) |
| selCode | output | 9 | Effective per-port source code, 3 bits per port |
| preEmph | output | 3 | Per-port pre-emphasis enable |
| linMode | output | 1 | 1 = LIN interface, 0 = I2C |

## Verification
- **Register writes and the override:** these take effect at the clock edge that samples the strobe. The bench drives each write one nanosecond after an edge and checks one nanosecond after the following edge.
- **Power pin and data inputs:** these act combinationally. The bench checks them after a one-nanosecond settle, with no clock edge in between.
- **Straps:** strap values take effect only at the first edge after the power pin leaves low. The bench therefore checks strap effects only after a complete low-then-high power cycle, and checks that they are ignored after plain clock edges.

// File: rtl/xbar_route_pkg.sv
package xbar_route_pkg;

  localparam int unsigned XB_NIN  = 4;
  localparam int unsigned XB_NOUT = 3;
  localparam int unsigned XB_CW   = 3;

  // decoded three-level pin values
  localparam logic [1:0] TL_LOW  = 2'b00;
  localparam logic [1:0] TL_OPEN = 2'b01;
  localparam logic [1:0] TL_HIGH = 2'b10;

  // strobes and codes passed from control to datapath
  typedef struct packed {
    logic [XB_NOUT-1:0][XB_CW-1:0] sel;
    logic [XB_NOUT-1:0]            pe;
    logic                          sleep;
  } routeCmd_t;

  function automatic logic isOpen(input logic [1:0] lvl);
    return lvl[0];
  endfunction

  function automatic logic isLow(input logic [1:0] lvl);
    return lvl == TL_LOW;
  endfunction

endpackage

// File: rtl/xbar_route_ctl.sv
module xbar_route_ctl
  import xbar_route_pkg::*;
#(
  parameter int unsigned NUM_OUT = XB_NOUT,
  parameter int unsigned CODE_W  = XB_CW,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             pwrPin,
  input  logic [4*NUM_OUT-1:0]   strapPins,
  input  logic                   regWe,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [7:0]             regWdata,
  output routeCmd_t              cmd,
  output logic                   linMode
);

  localparam int unsigned NUM_STRAP = 2 * NUM_OUT;
  localparam int unsigned NUM_REG   = (NUM_OUT + 1) / 2;
  localparam int unsigned ACT_ADDR  = NUM_REG + 1;

  logic [NUM_OUT-1:0][CODE_W-1:0] regSrc;
  logic [NUM_OUT-1:0]             regPe;
  logic [4*NUM_OUT-1:0]           strapQ;
  logic                           overrideQ;
  logic                           prevDown;
  logic                           isDown;
  logic                           wake;
  logic                           wrOk;
  logic                           useReg;
  logic                           forcePe;

  assign isDown  = isLow(pwrPin);
  assign wake    = prevDown && !isDown;
  assign wrOk    = regWe && !isDown;
  assign forcePe = isOpen(pwrPin);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regSrc    <= '0;
      regPe     <= '0;
      strapQ    <= {NUM_STRAP{TL_OPEN}};
      overrideQ <= 1'b0;
      prevDown  <= 1'b1;
    end else begin
      prevDown <= isDown;
      if (wake) begin
        strapQ    <= strapPins;
        overrideQ <= 1'b0;
      end else if (wrOk && regAddr == ADDR_W'(ACT_ADDR) && regWdata == 8'hFF) begin
        overrideQ <= 1'b1;
      end
      for (int p = 0; p < int'(NUM_OUT); p++) begin
        if (wrOk && regAddr == ADDR_W'(p / 2 + 1)) begin
          if (p % 2 == 1) begin
            regSrc[p] <= regWdata[4 +: CODE_W];
            regPe[p]  <= regWdata[7];
          end else begin
            regSrc[p] <= regWdata[0 +: CODE_W];
            regPe[p]  <= regWdata[3];
          end
        end
      end
    end
  end

  always_comb begin
    linMode = 1'b1;
    for (int k = 0; k < int'(NUM_STRAP); k++) begin
      if (!isOpen(strapQ[2*k +: 2])) linMode = 1'b0;
    end
  end

  assign useReg    = linMode || overrideQ;
  assign cmd.sleep = isDown;

  for (genvar p = 0; p < NUM_OUT; p++) begin : g_port
    localparam int unsigned FIRST = NUM_STRAP - 1 - p;
    logic [1:0]        pinA;
    logic [1:0]        pinB;
    logic [CODE_W-1:0] strapCode;

    assign pinA = strapQ[2*FIRST +: 2];
    assign pinB = strapQ[2*p +: 2];

    always_comb begin
      strapCode = '0;
      if (isLow(pinA)) begin
        if (isLow(pinB))       strapCode = CODE_W'(2);
        else if (isOpen(pinB)) strapCode = CODE_W'(1);
        else                   strapCode = CODE_W'(3);
      end else if (isOpen(pinA) && isLow(pinB)) begin
        strapCode = CODE_W'(4);
      end
    end

    assign cmd.sel[p] = useReg ? regSrc[p] : strapCode;
    assign cmd.pe[p]  = forcePe || regPe[p];
  end

endmodule

// File: rtl/xbar_route_dp.sv
module xbar_route_dp
  import xbar_route_pkg::*;
#(
  parameter int unsigned NUM_IN  = XB_NIN,
  parameter int unsigned NUM_OUT = XB_NOUT,
  parameter int unsigned CODE_W  = XB_CW
) (
  input  routeCmd_t                 cmd,
  input  logic [NUM_IN-1:0]         dataIn,
  output logic [NUM_OUT-1:0]        dataOut,
  output logic [NUM_OUT-1:0]        outEn,
  output logic [NUM_OUT*CODE_W-1:0] selCode,
  output logic [NUM_OUT-1:0]        preEmph
);

  // code carried by each input in the select encoding
  function automatic logic [CODE_W-1:0] codeOf(input int idx);
    if (idx == 0) return CODE_W'(2);
    if (idx == 1) return CODE_W'(1);
    return CODE_W'(idx + 1);
  endfunction

  for (genvar p = 0; p < NUM_OUT; p++) begin : g_out
    logic [NUM_IN-1:0] hit;
    logic              live;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
      assign hit[i] = (cmd.sel[p] == codeOf(i));
    end

    assign live                      = !cmd.sleep && (|hit);
    assign outEn[p]                  = live;
    assign dataOut[p]                = live && (|(hit & dataIn));
    assign selCode[p*CODE_W +: CODE_W] = live ? cmd.sel[p] : '0;
    assign preEmph[p]                = !cmd.sleep && cmd.pe[p];
  end

endmodule

// File: rtl/xbar_route_ctrl.sv
module xbar_route_ctrl
  import xbar_route_pkg::*;
#(
  parameter int unsigned NUM_IN  = XB_NIN,
  parameter int unsigned NUM_OUT = XB_NOUT,
  parameter int unsigned CODE_W  = XB_CW,
  parameter int unsigned ADDR_W  = $clog2((NUM_OUT + 1) / 2 + 2)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [1:0]                pwrPin,
  input  logic [4*NUM_OUT-1:0]      strapPins,
  input  logic                      regWe,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [7:0]                regWdata,
  input  logic [NUM_IN-1:0]         dataIn,
  output logic [NUM_OUT-1:0]        dataOut,
  output logic [NUM_OUT-1:0]        outEn,
  output logic [NUM_OUT*CODE_W-1:0] selCode,
  output logic [NUM_OUT-1:0]        preEmph,
  output logic                      linMode
);

  routeCmd_t cmd;

  xbar_route_ctl #(
    .NUM_OUT (NUM_OUT),
    .CODE_W  (CODE_W),
    .ADDR_W  (ADDR_W)
  ) i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .pwrPin    (pwrPin),
    .strapPins (strapPins),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .cmd       (cmd),
    .linMode   (linMode)
  );

  xbar_route_dp #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .CODE_W  (CODE_W)
  ) i_dp (
    .cmd     (cmd),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .outEn   (outEn),
    .selCode (selCode),
    .preEmph (preEmph)
  );

endmodule

// File: rtl/xbar_route_chk.sv
module xbar_route_chk #(
  parameter int unsigned NUM_OUT = 3,
  parameter int unsigned CODE_W  = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [1:0]                pwrPin,
  input logic                      linMode,
  input logic [NUM_OUT-1:0]        dataOut,
  input logic [NUM_OUT-1:0]        outEn,
  input logic [NUM_OUT*CODE_W-1:0] selCode,
  input logic [NUM_OUT-1:0]        preEmph
);

  // R7: power-down silences every port
  a_r7_sleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    pwrPin == 2'b00 |-> (outEn == '0 && preEmph == '0 && selCode == '0 && dataOut == '0));

  // R10: a disabled port never drives a one
  a_r10_hiz_low: assert property (@(posedge clk) disable iff (!rstN)
    (dataOut & ~outEn) == '0);

  // R9: open power pin forces pre-emphasis everywhere
  a_r9_open_pe: assert property (@(posedge clk) disable iff (!rstN)
    pwrPin[0] |-> preEmph == '1);

  // R6 / R8: mode moves only right after a wake edge
  a_r8_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 2) && $past(pwrPin, 2) != 2'b00) |-> $stable(linMode));

endmodule

bind xbar_route_ctrl xbar_route_chk #(.NUM_OUT(NUM_OUT), .CODE_W(CODE_W)) i_chk (.*);

// File: tb/test_xbar_route_ctrl.sv
module test_xbar_route_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  pwrPin = 2'b10;
  logic [11:0] strapPins = {6{2'b01}};
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [3:0]  dataIn = '0;
  logic [2:0]  dataOut;
  logic [2:0]  outEn;
  logic [8:0]  selCode;
  logic [2:0]  preEmph;
  logic        linMode;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  xbar_route_ctrl i_xbar_route_ctrl (
    .clk(clk), .rstN(rstN), .pwrPin(pwrPin), .strapPins(strapPins),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .dataIn(dataIn),
    .dataOut(dataOut), .outEn(outEn), .selCode(selCode), .preEmph(preEmph),
    .linMode(linMode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWe = 1'b0;
  endtask

  task automatic powerCycle();
    pwrPin = 2'b00;
    tick();
    tick();
    pwrPin = 2'b10;
    tick();
  endtask

  function automatic int normCode(input int c);
    return (c >= 1 && c <= 4) ? c : 0;
  endfunction

  function automatic int srcOf(input int c);
    case (c)
      1: return 1;
      2: return 0;
      3: return 2;
      4: return 3;
      default: return -1;
    endcase
  endfunction

  // R4 pair decode: 0 low, 1 open, 2 high
  function automatic int strapCode(input int a, input int b);
    if (a == 0) return (b == 0) ? 2 : (b == 1) ? 1 : 3;
    if (a == 1) return (b == 0) ? 4 : 0;
    return 0;
  endfunction

  task automatic checkRoute(input string req, input int c0, input int c1, input int c2);
    int ce[3];
    ce[0] = normCode(c0); ce[1] = normCode(c1); ce[2] = normCode(c2);
    for (int d = 0; d < 16; d++) begin
      dataIn = 4'(d);
      #1;
      for (int p = 0; p < 3; p++) begin
        int s = srcOf(ce[p]);
        chk({req, " sel"}, 32'(selCode[p*3 +: 3]), 32'(ce[p]));
        chk({req, " en"}, 32'(outEn[p]), 32'(s >= 0));
        chk({req, " data"}, 32'(dataOut[p]), (s >= 0) ? 32'(d[s]) : 32'd0);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rstN = 1'b1;
    tick();
    dataIn = 4'hF;
    #1;
    // R1 reset state
    chk("R1 lin", 32'(linMode), 32'd1);
    chk("R1 en", 32'(outEn), 32'd0);
    chk("R1 sel", 32'(selCode), 32'd0);
    chk("R1 pe", 32'(preEmph), 32'd0);
    chk("R1 data", 32'(dataOut), 32'd0);

    // R2 / R3 / R10 sweep of register codes in LIN mode
    for (int c0 = 0; c0 < 8; c0++) begin
      for (int c1 = 0; c1 < 8; c1++) begin
        int c2 = (c0 + c1 + 3) % 8;
        wr(2'd1, {1'b0, 3'(c1), 1'b0, 3'(c0)});
        wr(2'd2, {4'hA, 1'b0, 3'(c2)});
        if (c0 > 4 || c1 > 4 || c2 > 4) checkRoute("R3", c0, c1, c2);
        else checkRoute("R2", c0, c1, c2);
      end
    end

    // R9 pre-emphasis from register bits, then forced by open pin
    wr(2'd1, 8'h8A);
    chk("R9 pe reg1", 32'(preEmph), 32'b011);
    wr(2'd2, 8'h08);
    chk("R9 pe reg2", 32'(preEmph), 32'b111);
    wr(2'd2, 8'hF3);
    chk("R9 pe bit3 off", 32'(preEmph), 32'b011);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    chk("R9 pe clear", 32'(preEmph), 32'b000);
    pwrPin = 2'b01;
    #1 chk("R9 open forces", 32'(preEmph), 32'b111);
    pwrPin = 2'b11;
    #1 chk("R9 alt open forces", 32'(preEmph), 32'b111);
    pwrPin = 2'b10;
    #1 chk("R9 high follows", 32'(preEmph), 32'b000);

    // R11 address 0 ignored
    wr(2'd1, 8'h32);
    wr(2'd2, 8'h04);
    wr(2'd0, 8'hFF);
    wr(2'd0, 8'h00);
    checkRoute("R11", 2, 3, 4);
    chk("R11 pe", 32'(preEmph), 32'd0);

    // R7 power-down
    pwrPin = 2'b00;
    dataIn = 4'hF;
    #1;
    chk("R7 en", 32'(outEn), 32'd0);
    chk("R7 sel", 32'(selCode), 32'd0);
    chk("R7 pe", 32'(preEmph), 32'd0);
    chk("R7 data", 32'(dataOut), 32'd0);
    wr(2'd1, 8'h11);
    wr(2'd2, 8'h01);
    pwrPin = 2'b10;
    tick();
    chk("R7 lin kept", 32'(linMode), 32'd1);
    checkRoute("R7", 2, 3, 4);

    // R6 strap change while powered in LIN mode
    strapPins = 12'h000;
    tick(); tick();
    chk("R6 lin", 32'(linMode), 32'd1);
    checkRoute("R6", 2, 3, 4);

    // R8 + R4 wake resamples straps: all low/low -> input 0
    powerCycle();
    chk("R8 lin", 32'(linMode), 32'd0);
    checkRoute("R8", 2, 2, 2);

    // R4 sweep of pin pairs
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        int ca[3];
        logic [11:0] s = '0;
        for (int p = 0; p < 3; p++) begin
          int pa = (a + p) % 3;
          int pb = (b + p) % 3;
          s[2*(5-p) +: 2] = 2'(pa);
          s[2*p +: 2] = 2'(pb);
          ca[p] = strapCode(pa, pb);
        end
        strapPins = s;
        powerCycle();
        chk("R4 lin", 32'(linMode), 32'd0);
        checkRoute("R4", ca[0], ca[1], ca[2]);
      end
    end

    // R5 override gate
    strapPins = {6{2'b10}};
    powerCycle();
    checkRoute("R5 straps", 0, 0, 0);
    wr(2'd1, 8'h43);
    checkRoute("R5 regs idle", 0, 0, 0);
    wr(2'd3, 8'h7E);
    checkRoute("R5 other value", 0, 0, 0);
    wr(2'd3, 8'hFF);
    checkRoute("R5 armed", 3, 4, 4);

    // R6 strap change with override armed
    strapPins = 12'h000;
    tick(); tick();
    chk("R6 lin ovr", 32'(linMode), 32'd0);
    checkRoute("R6 ovr", 3, 4, 4);

    // R8 wake clears override
    powerCycle();
    checkRoute("R8 cleared", 2, 2, 2);

    // R4 encoding 11 counts as open -> LIN, registers route
    strapPins = 12'hFFF;
    powerCycle();
    chk("R4 alt open lin", 32'(linMode), 32'd1);
    checkRoute("R4 alt open", 3, 4, 4);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule